// File: doc/BRIEF.md
# Constant-On-Time PWM Gate Sequencer

This block is the digital timing core of a synchronous step-down converter controller. It takes already digitized comparator flags: feedback below target, valley over-current while the low-side switch conducts, and switch-current zero crossing. From these it drives two gate enables, one for the high-side switch and one for the low-side switch, and the two are never high together. A switching cycle is not paced by a fixed clock. It begins when the feedback flag reports that the output has sagged below target. The high side then conducts for a one-shot interval loaded from a configuration input. That input stands in for the on-time that the analog side would derive from the input and output voltages.

Every high-side pulse is followed by a minimum off-time lockout. While the low side conducts, a valley over-current flag blocks new cycles. In light-load diode emulation, the low side is released at the current zero crossing, so the switching rate falls as the load drops. Dead time in both directions is counted in clock cycles from its own configuration input. A synchronous disable input parks both gates low.

Top module: `cot_gate_seq`

## Requirements
- R1: `hs_en_o` and `ls_en_o` are never high in the same clock cycle.
- R2: A cycle starts only while `fb_low_i` is high. From the idle or low-side state, with the off-time expired, `hs_en_o` goes high on the (D+1)-th rising edge after `fb_low_i` is first sampled high, where D = max(`dead_cfg_i`, 1). While `fb_low_i` stays low, no high-side pulse starts.
- R3: Each high-side pulse that is not cut short by disable lasts exactly max(`ton_cfg_i`, MIN_ON) cycles, with MIN_ON = 7 by default.
- R4: The off-time count starts when the high side falls. The next pulse cannot start before `toff_cfg_i` cycles have passed. With `fb_low_i` held high and no other limit active, the high-side low time between pulses is max(`toff_cfg_i`, D) + D + 1 cycles.
- R5: Exactly D cycles with both gates low separate a high-side fall from the next low-side rise. The same D cycles separate a low-side fall from the next high-side rise.
- R6: While `ls_en_o` is high and `valley_oc_i` is high, no cycle starts and the low side stays on. Once the flag clears, the cycle starts as in R2.
- R7: With `dem_en_i` high, `zero_cross_i` high while the low side is on turns `ls_en_o` off on the next cycle, and both gates stay low until the next cycle start. With `dem_en_i` low, `zero_cross_i` has no effect.
- R8: `disable_i` sampled high drives both gates low from the next cycle, and nothing starts while it is held. It also clears both timers, so after release a cycle starts as in R2 with no pending off-time.
- R9: After reset both gates are low, the block is idle, and no off-time is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disable_i | input | 1 | Synchronous global disable |
| fb_low_i | input | 1 | Feedback below target |
| valley_oc_i | input | 1 | Low-side current above valley limit |
| zero_cross_i | input | 1 | Switch current reached zero |
| dem_en_i | input | 1 | Diode-emulation enable |
| ton_cfg_i | input | CNT_W | On-time in cycles (clamped up to MIN_ON) |
| toff_cfg_i | input | CNT_W | Minimum off-time in cycles |
| dead_cfg_i | input | DT_W | Dead time in cycles (clamped up to 1) |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |

## Verification
The properties assume the flags are synchronous to `clk_i` and that the configuration inputs change only while disable is held or between pulses. Under that assumption, a pulse in flight never sees its length change. The bench changes configuration only inside a park step that asserts disable, and it drives every flag on the falling clock edge. The valley and zero-crossing flags are asserted only while the low side is on, which matches their sensing window. The on-time property counts only pulses that disable did not end early.

// File: rtl/cot_pkg.sv
package cot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DT_HS,
    ST_HS_ON,
    ST_DT_LS,
    ST_LS_ON
  } cot_state_e;
endpackage

// File: rtl/cot_clamp.sv
module cot_clamp #(
  parameter int W     = 8,
  parameter int FLOOR = 0
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o
);
  generate
    if (FLOOR == 0) begin : g_pass
      assign val_o = val_i;
    end else begin : g_floor
      assign val_o = (val_i < W'(FLOOR)) ? W'(FLOOR) : val_i;
    end
  endgenerate
endmodule

// File: rtl/cot_oneshot.sv
module cot_oneshot #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_o <= '0;
    else if (clr_i)          cnt_o <= '0;
    else if (load_i)         cnt_o <= len_i;
    else if (cnt_o != '0)    cnt_o <= cnt_o - W'(1);
  end
endmodule

// File: rtl/cot_gate_seq.sv
module cot_gate_seq
  import cot_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DT_W     = 4,
  parameter int MIN_ON   = 7,
  parameter int MIN_DEAD = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             disable_i,
  input  logic             fb_low_i,
  input  logic             valley_oc_i,
  input  logic             zero_cross_i,
  input  logic             dem_en_i,
  input  logic [CNT_W-1:0] ton_cfg_i,
  input  logic [CNT_W-1:0] toff_cfg_i,
  input  logic [DT_W-1:0]  dead_cfg_i,
  output logic             hs_en_o,
  output logic             ls_en_o
);
  cot_state_e       state_q, state_d;
  logic [CNT_W-1:0] ton_eff, ph_len, ph_cnt, off_cnt;
  logic [DT_W-1:0]  dead_eff;
  logic             ph_load, off_load, ph_last, off_done, start_ok;

  cot_clamp #(.W(CNT_W), .FLOOR(MIN_ON)) u_ton_clamp (
    .val_i(ton_cfg_i), .val_o(ton_eff)
  );
  cot_clamp #(.W(DT_W), .FLOOR(MIN_DEAD)) u_dead_clamp (
    .val_i(dead_cfg_i), .val_o(dead_eff)
  );

  // shared timer for dead-time and on-time phases
  cot_oneshot #(.W(CNT_W)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(disable_i),
    .load_i(ph_load), .len_i(ph_len), .cnt_o(ph_cnt)
  );
  // minimum off-time, runs from high-side fall
  cot_oneshot #(.W(CNT_W)) u_off (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(disable_i),
    .load_i(off_load), .len_i(toff_cfg_i), .cnt_o(off_cnt)
  );

  assign ph_last  = (ph_cnt <= CNT_W'(1));
  assign off_done = (off_cnt == '0);
  assign start_ok = fb_low_i && off_done;

  always_comb begin
    state_d  = state_q;
    ph_load  = 1'b0;
    ph_len   = CNT_W'(dead_eff);
    off_load = 1'b0;
    case (state_q)
      ST_IDLE: if (start_ok) begin
        state_d = ST_DT_HS;
        ph_load = 1'b1;
      end
      ST_LS_ON: begin
        if (start_ok && !valley_oc_i) begin
          state_d = ST_DT_HS;
          ph_load = 1'b1;
        end else if (dem_en_i && zero_cross_i) begin
          state_d = ST_IDLE;
        end
      end
      ST_DT_HS: if (ph_last) begin
        state_d = ST_HS_ON;
        ph_load = 1'b1;
        ph_len  = ton_eff;
      end
      ST_HS_ON: if (ph_last) begin
        state_d  = ST_DT_LS;
        ph_load  = 1'b1;
        off_load = 1'b1;
      end
      ST_DT_LS: if (ph_last) state_d = ST_LS_ON;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        state_q <= ST_IDLE;
    else if (disable_i) state_q <= ST_IDLE;
    else                state_q <= state_d;
  end

  assign hs_en_o = (state_q == ST_HS_ON);
  assign ls_en_o = (state_q == ST_LS_ON);
endmodule

// File: rtl/cot_gate_seq_chk.sv
module cot_gate_seq_chk #(
  parameter int CNT_W  = 8,
  parameter int MIN_ON = 7
) (
  input logic clk_i,
  input logic rst_ni,
  input logic disable_i,
  input logic valley_oc_i,
  input logic zero_cross_i,
  input logic dem_en_i,
  input logic hs_en_o,
  input logic ls_en_o
);
  logic [CNT_W:0] hs_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            hs_run <= '0;
    else if (!hs_en_o)      hs_run <= '0;
    else if (hs_run != '1)  hs_run <= hs_run + 1'b1;
  end

  assert_no_overlap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o));

  assert_min_on_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hs_en_o) && !$past(disable_i)) |-> (hs_run >= (CNT_W+1)'(MIN_ON)));

  assert_hs_rise_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> !$past(ls_en_o));

  assert_ls_rise_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_en_o) |-> !$past(hs_en_o));

  assert_valley_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ls_en_o && valley_oc_i && !(dem_en_i && zero_cross_i) && !disable_i) |=> ls_en_o);

  assert_dem_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ls_en_o && dem_en_i && zero_cross_i) |=> !ls_en_o);

  assert_disable_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> (!hs_en_o && !ls_en_o));
endmodule

bind cot_gate_seq cot_gate_seq_chk #(.CNT_W(CNT_W), .MIN_ON(MIN_ON)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .disable_i(disable_i),
  .valley_oc_i(valley_oc_i), .zero_cross_i(zero_cross_i), .dem_en_i(dem_en_i),
  .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
);

// File: tb/cot_gate_seq_tb_top.sv
module cot_gate_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int DT_W  = 4;
  localparam int MIN_ON = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dis, fb_low, valley, zc, dem;
  logic [CNT_W-1:0] ton, toff;
  logic [DT_W-1:0]  dead;
  logic hs, ls;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // monitor state
  int hs_run, gap_run, bl_run, last_on, last_gap, dt_hl, dt_lh, rises, overlap;
  bit prev_h, prev_l, last_src_hs, seen_pulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  cot_gate_seq #(.CNT_W(CNT_W), .DT_W(DT_W), .MIN_ON(MIN_ON)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .disable_i(dis), .fb_low_i(fb_low),
    .valley_oc_i(valley), .zero_cross_i(zc), .dem_en_i(dem),
    .ton_cfg_i(ton), .toff_cfg_i(toff), .dead_cfg_i(dead),
    .hs_en_o(hs), .ls_en_o(ls)
  );

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      hs_run = 0; gap_run = 0; bl_run = 0; last_on = 0; last_gap = 0;
      dt_hl = 0; dt_lh = 0; rises = 0; overlap = 0;
      prev_h = 0; prev_l = 0; last_src_hs = 0; seen_pulse = 0;
    end else begin
      if (hs && ls) overlap++;
      if (hs) begin
        if (!prev_h) begin
          rises++;
          if (seen_pulse) last_gap = gap_run;
          if (!last_src_hs) dt_lh = bl_run;
          gap_run = 0;
        end
        hs_run++;
      end else begin
        if (prev_h) begin last_on = hs_run; hs_run = 0; seen_pulse = 1; end
        gap_run++;
      end
      if (ls && !prev_l && last_src_hs) dt_hl = bl_run;
      if (!hs && !ls) bl_run++;
      else begin bl_run = 0; last_src_hs = hs; end
      prev_h = hs; prev_l = ls;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic park(input int t_on, input int t_off, input int t_dead);
    dis = 1; fb_low = 0; valley = 0; zc = 0; dem = 0;
    ton = CNT_W'(t_on); toff = CNT_W'(t_off); dead = DT_W'(t_dead);
    tick(2);
    dis = 0;
    tick(1);
  endtask

  task automatic t_reset();
    tick(1);
    chk(!hs && !ls, "R9 gates low after reset", {hs, ls}, 0);
    tick(20);
    chk(rises == 0, "R2 no start while feedback high", rises, 0);
  endtask

  task automatic t_pulse();
    int snap;
    park(12, 40, 3);
    fb_low = 1;
    tick(3);
    chk(!hs, "R2 start latency early", hs, 0);
    tick(1);
    chk(hs, "R2 start latency D+1", hs, 1);
    tick(300);
    chk(last_on == 12, "R3 on-time", last_on, 12);
    chk(last_gap == 44, "R4 off gap", last_gap, 44);
    chk(dt_hl == 3, "R5 dead hs->ls", dt_hl, 3);
    chk(dt_lh == 3, "R5 dead ls->hs", dt_lh, 3);
    fb_low = 0;
    tick(100);
    snap = rises;
    tick(100);
    chk(rises == snap, "R2 no start with feedback high", rises, snap);
    chk(ls, "R7 low side stays on without diode emulation", ls, 1);
  endtask

  task automatic t_clamp();
    park(2, 0, 0);
    fb_low = 1;
    tick(100);
    chk(last_on == MIN_ON, "R3 on-time clamp", last_on, MIN_ON);
    chk(dt_hl == 1, "R5 dead clamp", dt_hl, 1);
    chk(last_gap == 3, "R4 off gap short toff", last_gap, 3);
    fb_low = 0;
  endtask

  task automatic t_valley();
    int snap;
    park(5, 10, 2);
    fb_low = 1;
    tick(3);
    fb_low = 0;
    tick(40);
    chk(ls, "R6 low side on before valley", ls, 1);
    valley = 1; fb_low = 1;
    snap = rises;
    tick(50);
    chk(rises == snap, "R6 valley blocks start", rises, snap);
    chk(ls, "R6 low side held", ls, 1);
    valley = 0;
    tick(2);
    chk(!hs, "R6 restart latency early", hs, 0);
    tick(1);
    chk(hs, "R6 restart after valley clears", hs, 1);
    fb_low = 0;
    tick(30);
  endtask

  task automatic t_dem();
    park(5, 4, 2);
    fb_low = 1;
    tick(3);
    fb_low = 0;
    tick(20);
    chk(ls, "R7 low side on", ls, 1);
    dem = 1; zc = 1;
    tick(1);
    chk(!ls, "R7 zero cross releases low side", ls, 0);
    tick(10);
    chk(!ls && !hs, "R7 both stay low", {hs, ls}, 0);
    dem = 0;
    fb_low = 1;
    tick(3);
    fb_low = 0;
    tick(20);
    chk(ls, "R7 zero cross ignored when disabled", ls, 1);
    zc = 0;
  endtask

  task automatic t_disable();
    int snap;
    park(8, 6, 2);
    fb_low = 1;
    tick(37);
    dis = 1;
    tick(1);
    chk(!hs && !ls, "R8 disable forces low", {hs, ls}, 0);
    snap = rises;
    tick(30);
    chk(rises == snap && !hs && !ls, "R8 nothing starts while disabled", rises, snap);
    dis = 0;
    tick(2);
    chk(!hs, "R8 restart latency early", hs, 0);
    tick(1);
    chk(hs, "R8 restart with no pending off-time", hs, 1);
    fb_low = 0;
    tick(30);
  endtask

  initial begin
    dis = 0; fb_low = 0; valley = 0; zc = 0; dem = 0;
    ton = 8'd10; toff = 8'd10; dead = 4'd2;
    tick(3);
    rst_n = 1;
    t_reset();
    t_pulse();
    t_clamp();
    t_valley();
    t_dem();
    t_disable();
    chk(overlap == 0, "R1 no overlap", overlap, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule